// File: doc/BRIEF.md
# Carry-Select Adder with Pre-Sum Carry Selection

This block adds two operands and an input carry in pure combinational logic. It gives an operand-wide sum and a carry-out. A first stage forms per-bit propagate (XOR) and generate (AND) words. Two ripple carry generators then build complete carry words in parallel: one assumes an input carry of zero and the other assumes one. The real input carry chooses between the two words before any sum bit is formed. A last row of XOR gates combines the chosen carry word with the propagate word.

The carry word computed under an assumed carry of one always covers the word computed under zero. Because of this, the selection needs only one AND-OR gate per bit and no full multiplexer. The width is a parameter; 16, 32 and 64 bits are the intended sizes. The block sits inside a wider arithmetic datapath and has no registers of its own.

Top module: `csel_adder`

## Requirements
- R1: For every width, {carry_out, sum} equals op_a + op_b + carry_in taken as unsigned numbers.
- R2: When op_a AND op_b is zero and carry_in is 0, sum equals op_a OR op_b and carry_out is 0 (no bit generates a carry).
- R3: With carry_in at 0, carry_out equals bit WIDTH of op_a + op_b.
- R4: For fixed operands, carry_out with carry_in at 1 is never lower than carry_out with carry_in at 0. Inside the block, every bit set in the zero-assumed carry word is also set in the one-assumed word.
- R5: For fixed operands, sum with carry_in at 1 equals sum with carry_in at 0 plus one, modulo 2^WIDTH.
- R6: Sum bit 0 equals op_a[0] XOR op_b[0] XOR carry_in.
- R7: Sum bits WIDTH-1 down to 1 equal the upper bits of the arithmetic result of R1.
- R8: An all-ones operand plus zero with carry_in at 1 yields sum 0 and carry_out 1, because the carry ripples across every bit.
- R9: The design is correct at widths 8, 16, 32 and 64. WIDTH must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Input carry; selects the carry word |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The immediate assertions are checked only when all operands and the input carry hold known 0/1 values; they are skipped while any of these is X or Z. The bench drives every input from time zero and changes all inputs together. It then waits a settling delay before sampling, so no check sees a half-updated input set. The 8-bit instance is driven with every possible operand pair and input carry. The wider instances get seeded random operands plus directed patterns: the full propagate chain, zero, alternating bits, and operands with no common set bits.

// File: rtl/csel_pkg.sv
package csel_pkg;
    // Default operand width; 16, 32 and 64 are the intended sizes.
    parameter int unsigned CSEL_WIDTH_DEF = 32;
    // Narrowest width at which the final-sum stage has an upper field.
    parameter int unsigned CSEL_WIDTH_MIN = 2;
endpackage

// File: rtl/csel_halfsum.sv
module csel_halfsum #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] prop_w,
    output logic [WIDTH-1:0] gen_w
);
    always_comb begin
        prop_w = op_a ^ op_b;
        gen_w  = op_a & op_b;
    end

    // R2: a bit never both propagates and generates
    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            a_r2_prop_gen_disjoint: assert ((prop_w & gen_w) == '0)
                else $error("propagate and generate overlap");
        end
    end
endmodule

// File: rtl/csel_carrygen.sv
module csel_carrygen #(
    parameter int unsigned WIDTH    = 32,
    parameter bit          ASSUMED_CIN = 1'b0
) (
    input  logic [WIDTH-1:0] prop_w,
    input  logic [WIDTH-1:0] gen_w,
    output logic [WIDTH-1:0] carry_w
);
    // Bit 0 folds the fixed input carry in as a constant.
    if (ASSUMED_CIN) begin : g_lsb_one
        assign carry_w[0] = gen_w[0] | prop_w[0];
    end else begin : g_lsb_zero
        assign carry_w[0] = gen_w[0];
    end

    for (genvar i = 1; i < WIDTH; i++) begin : g_ripple
        assign carry_w[i] = gen_w[i] | (prop_w[i] & carry_w[i-1]);
    end
endmodule

// File: rtl/csel_select.sv
module csel_select #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] carry_z_w,
    input  logic [WIDTH-1:0] carry_o_w,
    input  logic             carry_in,
    output logic [WIDTH-1:0] carry_sel_w
);
    // One AND-OR per bit: relies on carry_o_w covering carry_z_w.
    always_comb begin
        carry_sel_w = carry_z_w | ({WIDTH{carry_in}} & carry_o_w);
    end

    // R4: the one-assumed word covers the zero-assumed word bit by bit
    always_comb begin
        if (!$isunknown({carry_z_w, carry_o_w})) begin
            a_r4_word_dominance: assert ((carry_z_w & ~carry_o_w) == '0)
                else $error("carry-1 word fails to cover carry-0 word");
        end
    end

    // R5: the chosen word matches the generator named by carry_in
    always_comb begin
        if (!$isunknown({carry_z_w, carry_o_w, carry_in})) begin
            a_r5_select_matches: assert (carry_sel_w == (carry_in ? carry_o_w : carry_z_w))
                else $error("selected carry word mismatch");
        end
    end
endmodule

// File: rtl/csel_finalsum.sv
module csel_finalsum #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop_w,
    input  logic [WIDTH-2:0] carry_lo_w,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum
);
    always_comb begin
        sum[0]         = prop_w[0] ^ carry_in;
        sum[WIDTH-1:1] = prop_w[WIDTH-1:1] ^ carry_lo_w;
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter int unsigned WIDTH = CSEL_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int unsigned RES_W = WIDTH + 1;

    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] carry_z_w;
    logic [WIDTH-1:0] carry_o_w;
    logic [WIDTH-1:0] carry_sel_w;

    initial begin
        if (WIDTH < CSEL_WIDTH_MIN) $error("WIDTH below minimum");
    end

    csel_halfsum #(.WIDTH(WIDTH)) u_halfsum (
        .op_a   (op_a),
        .op_b   (op_b),
        .prop_w (prop_w),
        .gen_w  (gen_w)
    );

    csel_carrygen #(.WIDTH(WIDTH), .ASSUMED_CIN(1'b0)) u_carry_zero (
        .prop_w  (prop_w),
        .gen_w   (gen_w),
        .carry_w (carry_z_w)
    );

    csel_carrygen #(.WIDTH(WIDTH), .ASSUMED_CIN(1'b1)) u_carry_one (
        .prop_w  (prop_w),
        .gen_w   (gen_w),
        .carry_w (carry_o_w)
    );

    csel_select #(.WIDTH(WIDTH)) u_select (
        .carry_z_w   (carry_z_w),
        .carry_o_w   (carry_o_w),
        .carry_in    (carry_in),
        .carry_sel_w (carry_sel_w)
    );

    csel_finalsum #(.WIDTH(WIDTH)) u_finalsum (
        .prop_w     (prop_w),
        .carry_lo_w (carry_sel_w[WIDTH-2:0]),
        .carry_in   (carry_in),
        .sum        (sum)
    );

    assign carry_out = carry_sel_w[WIDTH-1];

    // R1: the ports agree with unsigned arithmetic
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            a_r1_arith_match: assert ({carry_out, sum} ==
                    (RES_W'(op_a) + RES_W'(op_b) + RES_W'(carry_in)))
                else $error("sum differs from arithmetic result");
        end
    end

    // R6: the least significant sum bit
    always_comb begin
        if (!$isunknown({op_a[0], op_b[0], carry_in})) begin
            a_r6_lsb_sum: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
                else $error("sum bit 0 wrong");
        end
    end
endmodule

// File: tb/csel_adder_tb.sv
module csel_adder_tb;
    localparam int unsigned WDOG_CYCLES = 190000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    int unsigned n_cycles = 0;
    bit          done     = 1'b0;

    logic [7:0]  a8,  b8;   logic c8;   logic [7:0]  s8;   logic co8;
    logic [15:0] a16, b16;  logic c16;  logic [15:0] s16;  logic co16;
    logic [31:0] a32, b32;  logic c32;  logic [31:0] s32;  logic co32;
    logic [63:0] a64, b64;  logic c64;  logic [63:0] s64;  logic co64;

    csel_adder #(.WIDTH(32)) u_dut (
        .op_a(a32), .op_b(b32), .carry_in(c32), .sum(s32), .carry_out(co32));
    csel_adder #(.WIDTH(8)) u_dut8 (
        .op_a(a8), .op_b(b8), .carry_in(c8), .sum(s8), .carry_out(co8));
    csel_adder #(.WIDTH(16)) u_dut16 (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));
    csel_adder #(.WIDTH(64)) u_dut64 (
        .op_a(a64), .op_b(b64), .carry_in(c64), .sum(s64), .carry_out(co64));

    function automatic logic [64:0] ref_add(int w, logic [63:0] a, logic [63:0] b, logic c);
        logic [64:0] mask_op = (65'd1 << w) - 65'd1;
        logic [64:0] mask_rs = (65'd1 << (w + 1)) - 65'd1;
        return (({1'b0, a} & mask_op) + ({1'b0, b} & mask_op) + {64'd0, c}) & mask_rs;
    endfunction

    task automatic chk(string tag, logic [64:0] got, logic [64:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // Apply to every wide instance, settle, compare against reference (R1, R7, R9).
    task automatic apply_wide(logic [63:0] a, logic [63:0] b, logic c, string tag);
        a16 = a[15:0]; b16 = b[15:0]; c16 = c;
        a32 = a[31:0]; b32 = b[31:0]; c32 = c;
        a64 = a;       b64 = b;       c64 = c;
        #2;
        chk({tag, " R1 w16"}, {48'd0, co16, s16}, ref_add(16, a, b, c));
        chk({tag, " R1 w32"}, {32'd0, co32, s32}, ref_add(32, a, b, c));
        chk({tag, " R1 w64"}, {co64, s64},       ref_add(64, a, b, c));
        chk({tag, " R7 w64 upper"}, {2'd0, s64[63:1]}, {1'b0, ref_add(64, a, b, c)[63:1]});
        #3;
    endtask

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        a64 = '0; b64 = '0; c64 = 1'b0;
    end

    always @(posedge clk) begin
        n_cycles++;
        if (!done && n_cycles >= WDOG_CYCLES) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", n_cycles, WDOG_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #2;
        // Initial state: all-zero inputs give zero outputs.
        chk("R1 zero inputs w32", {32'd0, co32, s32}, 65'd0);
        #3;

        // R9 / R1 / R6: exhaustive 8-bit space.
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    a8 = 8'(ia); b8 = 8'(ib); c8 = ic[0];
                    #2;
                    chk("R9 R1 w8 exhaustive", {56'd0, co8, s8},
                        ref_add(8, 64'(ia), 64'(ib), ic[0]));
                    if (ia[1:0] == 2'b00)
                        chk("R6 w8 lsb", {64'd0, s8[0]}, {64'd0, a8[0] ^ b8[0] ^ c8});
                    #3;
                end
            end
        end

        // R8: full propagate chain.
        apply_wide('1, '0, 1'b1, "R8 ones+0+1");
        a64 = '1; b64 = '0; c64 = 1'b1; #2;
        chk("R8 w64 ripple", {co64, s64}, {1'b1, 64'd0});
        #3;
        apply_wide('0, '1, 1'b1, "R8 0+ones+1");
        apply_wide('1, '1, 1'b1, "corner ones+ones+1");
        apply_wide('1, '1, 1'b0, "corner ones+ones+0");
        apply_wide(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "alt+1");
        apply_wide(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b0, "alt same");

        // Random mix.
        for (int k = 0; k < 1500; k++) begin
            logic [63:0] ra = rnd64();
            logic [63:0] rb = rnd64();
            apply_wide(ra, rb, $urandom() % 2 == 1, "rand");
        end

        // R2: disjoint operands, carry_in 0.
        for (int k = 0; k < 200; k++) begin
            logic [63:0] ra = rnd64();
            logic [63:0] rb = rnd64() & ~ra;
            a32 = ra[31:0]; b32 = rb[31:0]; c32 = 1'b0;
            #2;
            chk("R2 disjoint sum", {33'd0, s32}, {33'd0, ra[31:0] | rb[31:0]});
            chk("R2 disjoint cout", {64'd0, co32}, 65'd0);
            #3;
        end

        // R3, R4, R5: paired carry_in on identical operands.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] ra = $urandom();
            logic [31:0] rb = $urandom();
            logic [31:0] sum0;
            logic        co0;
            logic [32:0] plain;
            if (k < 20) rb = ~ra;
            plain = {1'b0, ra} + {1'b0, rb};
            a32 = ra; b32 = rb; c32 = 1'b0;
            #2;
            sum0 = s32; co0 = co32;
            chk("R3 cout cin0", {64'd0, co32}, {64'd0, plain[32]});
            #3;
            c32 = 1'b1;
            #2;
            chk("R4 cout monotone", {64'd0, (co32 < co0)}, 65'd0);
            chk("R5 sum plus one", {33'd0, s32}, {33'd0, sum0 + 32'd1});
            #3;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule